// File: doc/BRIEF.md
# Dual Comparator Logic-Combine and Event Latch

This block takes the synchronous digital results of two comparators and turns them into four outputs. Operand A comes from channel 0 and operand B from channel 1. Each channel evaluates a programmable two-input boolean function of A and B, chosen by a 4-bit code. The result can go out directly, or it can set a sticky flag that holds the event until something clears it. Each channel has two outputs: a primary output that feeds downstream sensing and interrupt logic, and a pin-bound output. Each of the two has its own choice between the direct result and the held flag.

The held flag of a channel is cleared in one of two ways, selected per channel. In the first, any write to the output-control register clears it. In the second, the flag clears when the other channel's function output rises. In that mode the two channels form a cross-coupled capture pair: one channel marks the start of an event and the other marks its end. Three byte-wide control registers sit on a simple write/read port: channel enables, output control and function codes. A pair of stored analog-routing bits is passed out unchanged.

Top module: `dual_cmp_combine`

## Requirements
- R1: After reset all three control registers read 0x00, and every output is 0.
- R2: The enable register is at address 0x7A, output control at 0x7B and function codes at 0x7C. The enable register keeps only bit 0 (channel 0) and bit 4 (channel 1), and its other bits read 0. The other two registers keep all 8 bits. A read of any other address returns 0x00, and a write to any other address changes nothing. Read data is combinational from the address.
- R3: When a channel's enable bit is 0, its operand is forced to 0 for both function evaluations.
- R4: Each function output equals bit {~A,~B} of its 4-bit code, combinationally, in the same cycle. Bits 3:0 of the code register drive channel 0 and bits 7:4 drive channel 1. For example, code 0x6 gives A XOR B, 0x8 gives A NOR B, 0x3 gives A, 0x5 gives B and 0xF gives 1.
- R5: Primary-output select (control bit 0 for channel 0, bit 4 for channel 1): a value of 0 routes the function output and a value of 1 routes the held flag.
- R6: Pin-output select (control bit 2 for channel 0, bit 6 for channel 1) has the same meaning for the pin output.
- R7: A channel's held flag becomes 1 at the clock edge where its own function output is 1 and no clear applies. It then stays 1 until a clear.
- R8: With the clear-source bit at 0 (control bit 1 for channel 0, bit 5 for channel 1), any write to 0x7B clears the flag at that edge. The clear-source value that applies is the one held before the write.
- R9: With the clear-source bit at 1, a channel's flag clears at an edge where the other channel's function output is 1 and was 0 at the previous edge. Writes to 0x7B then leave the flag alone.
- R10: When a set and a clear apply at the same edge, the flag ends up 0.
- R11: Control bits 3 and 7 appear on the analog-link outputs of channels 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_in | input | 2 | Comparator bits: [0] is operand A, [1] is operand B |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| main_out | output | 2 | Primary output per channel |
| pin_out | output | 2 | Pin-bound output per channel |
| ana_link | output | 2 | Stored analog-routing bits per channel |

## Verification
The function outputs, read data and analog-link bits follow the inputs and stored registers in the same cycle. A held flag, or a register change, shows at the outputs one edge after the cycle that caused it. The driver sets the inputs after a falling edge. It then queues the values it expects before the next rising edge, using a model state that has advanced exactly one edge per driven cycle. The monitor compares each queued item against the ports in that same half period, so every same-cycle and next-cycle effect is checked in the cycle where it is due.

// File: rtl/cmpl_pkg.sv
package cmpl_pkg;
   // per-channel nibble inside the output-control register
   localparam int NIB_W     = 4;
   localparam int F_MAINSEL = 0;
   localparam int F_CLRSRC  = 1;
   localparam int F_PINSEL  = 2;
   localparam int F_ANALOG  = 3;
   localparam int N_CHAN    = 2;

   // truth-table pick: index built from the inverted operands
   function automatic logic code_pick(input logic [3:0] code, input logic a, input logic b);
      logic [1:0] idx;
      idx = {~a, ~b};
      return code[idx];
   endfunction
endpackage

// File: rtl/cmpl_regs.sv
module cmpl_regs #(
   parameter int                ADDR_W    = 8,
   parameter int                DATA_W    = 8,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h7A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [1:0]        en_q,
   output logic [DATA_W-1:0] ctl_q,
   output logic [DATA_W-1:0] code_q,
   output logic              ctl_wr
);
   localparam logic [ADDR_W-1:0] A_EN   = BASE_ADDR;
   localparam logic [ADDR_W-1:0] A_CTL  = BASE_ADDR + ADDR_W'(1);
   localparam logic [ADDR_W-1:0] A_CODE = BASE_ADDR + ADDR_W'(2);
   localparam int                EN1_BIT = DATA_W / 2;

   logic hit_en, hit_ctl, hit_code;

   assign hit_en   = (addr == A_EN);
   assign hit_ctl  = (addr == A_CTL);
   assign hit_code = (addr == A_CODE);
   assign ctl_wr   = we && hit_ctl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         ctl_q  <= '0;
         code_q <= '0;
      end else if (we) begin
         if (hit_en)   en_q   <= {wdata[EN1_BIT], wdata[0]};
         if (hit_ctl)  ctl_q  <= wdata;
         if (hit_code) code_q <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      if (hit_en) begin
         rdata[0]       = en_q[0];
         rdata[EN1_BIT] = en_q[1];
      end
      if (hit_ctl)  rdata = ctl_q;
      if (hit_code) rdata = code_q;
   end
endmodule

// File: rtl/cmpl_lut.sv
module cmpl_lut #(
   parameter int CODE_W = 4
) (
   input  logic [CODE_W-1:0] code,
   input  logic              opa,
   input  logic              opb,
   output logic              y
);
   generate
      if (CODE_W != 4) begin : g_bad_width
         $error("cmpl_lut: CODE_W must be 4 for a two-input table");
      end
   endgenerate

   assign y = cmpl_pkg::code_pick(code, opa, opb);
endmodule

// File: rtl/cmpl_chan.sv
module cmpl_chan (
   input  logic clk,
   input  logic rst_n,
   input  logic own_fn,
   input  logic peer_rise,
   input  logic ctl_wr,
   input  logic sel_main,
   input  logic sel_pin,
   input  logic clr_src,
   output logic flag_q,
   output logic main_o,
   output logic pin_o
);
   logic clr;

   // the clear-source bit before any same-cycle write governs this edge
   assign clr = clr_src ? peer_rise : ctl_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_q <= 1'b0;
      else if (clr)    flag_q <= 1'b0;
      else if (own_fn) flag_q <= 1'b1;
   end

   assign main_o = sel_main ? flag_q : own_fn;
   assign pin_o  = sel_pin  ? flag_q : own_fn;
endmodule

// File: rtl/dual_cmp_combine.sv
module dual_cmp_combine #(
   parameter int                ADDR_W    = 8,
   parameter int                DATA_W    = 8,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h7A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cmp_in,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [1:0]        main_out,
   output logic [1:0]        pin_out,
   output logic [1:0]        ana_link
);
   import cmpl_pkg::*;

   localparam int NCH = N_CHAN;

   generate
      if (DATA_W != NCH * NIB_W) begin : g_bad_data
         $error("dual_cmp_combine: DATA_W must hold one nibble per channel");
      end
      if (ADDR_W < 7) begin : g_bad_addr
         $error("dual_cmp_combine: ADDR_W too small for the register window");
      end
   endgenerate

   logic [1:0]        en_q;
   logic [DATA_W-1:0] ctl_q;
   logic [DATA_W-1:0] code_q;
   logic              ctl_wr;
   logic [NCH-1:0]    opnd;
   logic [NCH-1:0]    fn_o;
   logic [NCH-1:0]    fn_d;
   logic [NCH-1:0]    rise;
   logic [NCH-1:0]    flag_q;

   cmpl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
      .rdata(bus_rdata), .en_q(en_q), .ctl_q(ctl_q), .code_q(code_q), .ctl_wr(ctl_wr)
   );

   // a disabled channel presents 0 as its operand
   assign opnd = cmp_in & en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fn_d <= '0;
      else        fn_d <= fn_o;
   end

   assign rise = fn_o & ~fn_d;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      localparam int PEER = NCH - 1 - c;

      cmpl_lut #(.CODE_W(NIB_W)) u_lut (
         .code(code_q[c*NIB_W +: NIB_W]), .opa(opnd[0]), .opb(opnd[1]), .y(fn_o[c])
      );

      cmpl_chan u_chan (
         .clk(clk), .rst_n(rst_n),
         .own_fn(fn_o[c]), .peer_rise(rise[PEER]), .ctl_wr(ctl_wr),
         .sel_main(ctl_q[c*NIB_W + F_MAINSEL]),
         .sel_pin(ctl_q[c*NIB_W + F_PINSEL]),
         .clr_src(ctl_q[c*NIB_W + F_CLRSRC]),
         .flag_q(flag_q[c]), .main_o(main_out[c]), .pin_o(pin_out[c])
      );

      assign ana_link[c] = ctl_q[c*NIB_W + F_ANALOG];
   end
endmodule

// File: rtl/cmpl_checker.sv
module cmpl_checker #(
   parameter int                ADDR_W    = 8,
   parameter int                DATA_W    = 8,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h7A
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [1:0]        en_q,
   input logic [DATA_W-1:0] ctl_q,
   input logic [DATA_W-1:0] code_q,
   input logic [1:0]        fn_o,
   input logic [1:0]        fn_d,
   input logic [1:0]        flag_q
);
   localparam logic [ADDR_W-1:0] A_CTL = BASE_ADDR + ADDR_W'(1);

   logic ctl_hit;
   assign ctl_hit = bus_we && (bus_addr == A_CTL);

   // R3: disabled channel 0 with code "A" never yields 1
   p_off_forces_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q[0] && code_q[3:0] == 4'h3) |-> !fn_o[0]);

   // R7: flag of channel 0 sets when its function is high and no clear applies
   p_flag_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fn_o[0] && !ctl_q[1] && !ctl_hit) |=> flag_q[0]);

   // R7: channel 1 flag rises only after its function was high
   p_flag_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q[1]) |-> $past(fn_o[1]));

   // R8: a control write clears channel 0 in write-clear mode
   p_write_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_hit && !ctl_q[1]) |=> !flag_q[0]);

   // R9: channel 1 clears on a rise of channel 0's function
   p_cross_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q[5] && fn_o[0] && !fn_d[0]) |=> !flag_q[1]);

   // R10: clear beats a simultaneous set on channel 0
   p_clear_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q[1] && fn_o[1] && !fn_d[1] && fn_o[0]) |=> !flag_q[0]);
endmodule

bind dual_cmp_combine cmpl_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
   .en_q(en_q), .ctl_q(ctl_q), .code_q(code_q),
   .fn_o(fn_o), .fn_d(fn_d), .flag_q(flag_q)
);

// File: tb/tb_dual_cmp_combine.sv
module tb_dual_cmp_combine;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] cmp_in = 2'b00;
   logic       bus_we = 1'b0;
   logic [7:0] bus_addr = 8'h00;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic [1:0] main_out, pin_out, ana_link;

   dual_cmp_combine dut (
      .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .main_out(main_out), .pin_out(pin_out), .ana_link(ana_link)
   );

   always #5 clk = ~clk;

   typedef struct {
      logic [1:0] mo;
      logic [1:0] po;
      logic [1:0] an;
      logic [7:0] rd;
      string      tag;
   } exp_t;

   exp_t q[$];
   int   n_chk = 0;
   int   n_err = 0;
   bit   done  = 1'b0;

   // model state
   logic [1:0] m_en   = 2'b00;
   logic [7:0] m_ctl  = 8'h00;
   logic [7:0] m_code = 8'h00;
   logic [1:0] m_flag = 2'b00;
   logic [1:0] m_fnd  = 2'b00;

   function automatic logic fnv(input logic [3:0] c, input logic a, input logic b);
      return c[{~a, ~b}];
   endfunction

   task automatic cmp(input string tag, input string fld, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", tag, fld, act, exp, $time);
      end
   endtask

   // monitor: pops one expected item per driven cycle
   always @(negedge clk) begin
      #3;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         cmp({e.tag, " main R5"}, "main_out", {6'b0, main_out}, {6'b0, e.mo});
         cmp({e.tag, " pin R6"}, "pin_out", {6'b0, pin_out}, {6'b0, e.po});
         cmp({e.tag, " ana R11"}, "ana_link", {6'b0, ana_link}, {6'b0, e.an});
         cmp({e.tag, " read R2"}, "bus_rdata", bus_rdata, e.rd);
      end
   end

   task automatic step(input logic a, input logic b, input logic we,
                       input logic [7:0] addr, input logic [7:0] data, input string tag);
      exp_t e;
      logic ea, eb, f0, f1, cw, c0, c1;
      @(negedge clk);
      cmp_in = {b, a}; bus_we = we; bus_addr = addr; bus_wdata = data;
      #2;
      ea = a & m_en[0];
      eb = b & m_en[1];
      f0 = fnv(m_code[3:0], ea, eb);
      f1 = fnv(m_code[7:4], ea, eb);
      e.mo = {m_ctl[4] ? m_flag[1] : f1, m_ctl[0] ? m_flag[0] : f0};
      e.po = {m_ctl[6] ? m_flag[1] : f1, m_ctl[2] ? m_flag[0] : f0};
      e.an = {m_ctl[7], m_ctl[3]};
      case (addr)
         8'h7A:   e.rd = {3'b0, m_en[1], 3'b0, m_en[0]};
         8'h7B:   e.rd = m_ctl;
         8'h7C:   e.rd = m_code;
         default: e.rd = 8'h00;
      endcase
      e.tag = tag;
      q.push_back(e);
      // advance model across the coming edge
      cw = we && (addr == 8'h7B);
      c0 = m_ctl[1] ? (f1 && !m_fnd[1]) : cw;
      c1 = m_ctl[5] ? (f0 && !m_fnd[0]) : cw;
      m_flag[0] = c0 ? 1'b0 : (f0 ? 1'b1 : m_flag[0]);
      m_flag[1] = c1 ? 1'b0 : (f1 ? 1'b1 : m_flag[1]);
      m_fnd = {f1, f0};
      if (we) begin
         if (addr == 8'h7A) m_en = {data[4], data[0]};
         if (addr == 8'h7B) m_ctl = data;
         if (addr == 8'h7C) m_code = data;
      end
   endtask

   task automatic wr(input logic [7:0] addr, input logic [7:0] data, input string tag);
      step(1'b0, 1'b0, 1'b1, addr, data, tag);
   endtask

   task automatic idle(input logic a, input logic b, input string tag);
      step(a, b, 1'b0, 8'h7B, 8'h00, tag);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: reset values
      step(0, 0, 0, 8'h7A, 0, "R1");
      step(1, 1, 0, 8'h7B, 0, "R1");
      step(0, 0, 0, 8'h7C, 0, "R1");

      // R2: map, readback, masked enable, stray address
      wr(8'h7A, 8'hFF, "R2");
      wr(8'h7C, 8'hA5, "R2");
      wr(8'h10, 8'hFF, "R2 stray");
      wr(8'h7B, 8'h5A, "R2");
      step(0, 0, 0, 8'h7A, 0, "R2");
      step(0, 0, 0, 8'h7B, 0, "R2");
      step(0, 0, 0, 8'h7C, 0, "R2");
      step(0, 0, 0, 8'h10, 0, "R2 stray");

      // R4: every code for both channels, all operand pairs
      wr(8'h7A, 8'h11, "R4");
      wr(8'h7B, 8'h00, "R4");
      for (int c = 0; c < 16; c++) begin
         wr(8'h7C, {c[3:0], 4'(15 - c)}, "R4");
         for (int ab = 0; ab < 4; ab++) idle(ab[0], ab[1], "R4");
      end

      // R3: disabled channels force operands low
      wr(8'h7C, 8'h53, "R3");
      wr(8'h7A, 8'h00, "R3");
      idle(1, 1, "R3");
      wr(8'h7A, 8'h01, "R3");
      idle(1, 1, "R3");
      wr(8'h7A, 8'h10, "R3");
      idle(1, 1, "R3");
      wr(8'h7A, 8'h11, "R3");
      idle(1, 1, "R3");

      // R5 and R7: flag capture and hold on primary outputs
      wr(8'h7B, 8'h11, "R5");
      idle(0, 0, "R7");
      idle(1, 0, "R7");
      idle(0, 0, "R7");
      idle(0, 0, "R7");
      idle(0, 1, "R7");
      idle(0, 0, "R7");
      // R8: any control write clears in write-clear mode
      wr(8'h7B, 8'h11, "R8");
      idle(0, 0, "R8");
      idle(1, 1, "R8");
      wr(8'h7B, 8'h11, "R8");
      idle(0, 0, "R8");

      // R9: cross clearing, write leaves flags alone
      wr(8'h7B, 8'h33, "R9");
      idle(1, 0, "R9");
      idle(0, 0, "R9");
      wr(8'h7B, 8'h33, "R9");
      idle(0, 0, "R9");
      idle(0, 1, "R9");
      idle(0, 0, "R9");
      idle(1, 0, "R9");
      idle(0, 0, "R9");

      // R10: clear wins over set (ch0 always true, ch1 = A)
      wr(8'h7C, 8'h3F, "R10");
      wr(8'h7B, 8'h03, "R10");
      idle(0, 0, "R10");
      idle(0, 0, "R10");
      idle(1, 0, "R10");
      idle(1, 0, "R10");
      idle(0, 0, "R10");

      // R6: pin select independent of primary select
      wr(8'h7C, 8'h53, "R6");
      wr(8'h7B, 8'h44, "R6");
      idle(1, 0, "R6");
      idle(0, 1, "R6");
      idle(0, 0, "R6");
      idle(1, 1, "R6");

      // R11: analog-link bits
      wr(8'h7B, 8'h08, "R11");
      idle(0, 0, "R11");
      wr(8'h7B, 8'h80, "R11");
      idle(0, 0, "R11");

      // mixed random traffic
      for (int i = 0; i < 600; i++) begin
         int r;
         logic [7:0] ad;
         r = $urandom_range(0, 9);
         case ($urandom_range(0, 3))
            0: ad = 8'h7A;
            1: ad = 8'h7B;
            2: ad = 8'h7C;
            default: ad = 8'h7D;
         endcase
         step(1'($urandom), 1'($urandom), r == 0, ad, 8'($urandom), "R4 R9 random");
      end

      @(negedge clk);
      #5;
      finish_run();
   end
endmodule